// File: doc/BRIEF.md
# TDM Serial Transmit Port with I2S-Style Framing

This block is a master-mode serial transmitter. It takes parallel audio words one per slot, packs them into time-division-multiplexed frames and sends them most-significant bit first on one data line. It generates the bit clock and a one-bit-wide frame sync pulse itself. A slot mask chooses which slots carry data. A programmable gap between the frame sync and the first data bit, together with a pairwise left/right swap, lets the same slot engine produce I2S-style two-channel framing: two slots and a one-bit gap.

Words are fetched on demand. At the start of every active slot the port raises `in_ready` for one system clock and names the logical channel it wants on `in_chan`. The upstream source answers in that same cycle with `in_data` and `in_valid`. If no word is offered, the slot is sent as zeros and a sticky underflow flag is set. All configuration inputs are sampled only when a frame begins. A change made while a frame is running therefore shows up from the next frame onward.

The controller has three states. IDLE: clock and frame sync are held low. GAP: the frame sync bit and any further delay bits, with the data line disabled. SLOT: words are being shifted. The transitions are:
- IDLE to GAP (delay > 0) or IDLE to SLOT (delay = 0), on a bit tick while enabled.
- GAP to SLOT, once the delay count is reached.
- SLOT to SLOT, either for the next bit, for the next slot, or for a new frame when the last bit of the last slot ends and the port is still enabled.
- SLOT to GAP, for a new frame with a nonzero delay.
- SLOT to IDLE, when the last bit of a frame ends with the enable low.

Top module: `tdm_tx_port`

## Requirements
- R1: The serial clock period is `cfg_div` system clocks, where `cfg_div` is even and at least 2. The clock is low for the first `cfg_div/2` clocks of each period and high for the rest. After reset, and whenever the port is idle, the serial clock and frame sync are held low.
- R2: A frame lasts `cfg_delay + cfg_nch*cfg_wlen` serial clock periods, with `cfg_wlen` at least 2. The frame sync is high for exactly the first of those periods in every frame.
- R3: A slot lasts `cfg_wlen` bit periods. It carries bits `cfg_wlen-1` down to 0 of the accepted word, in that order. Word bits above `cfg_wlen-1` are never sent.
- R4: The first data bit of slot 0 comes `cfg_delay` bit periods after the frame sync bit. The delay bits drive the data line to 0 with the output enable low. A delay of 1 with two slots gives I2S-style timing.
- R5: Bit p of `cfg_mask` enables slot position p. An inactive slot drives the data line to 0, holds `sd_oe_o` low and requests no word.
- R6: With `cfg_swap` = 0, slot position p requests channel p. With `cfg_swap` = 1, it requests channel p XOR 1 if that channel is below `cfg_nch`, otherwise channel p.
- R7: `in_ready` is high for exactly one system clock at the start of each active slot, so each frame has as many pulses as there are active slots. The word on `in_data` is taken in that cycle when `in_valid` is high.
- R8: An active slot that starts with `in_valid` low is sent as zeros with `sd_oe_o` high, and `underflow_o` is set. `underflow_o` stays set until reset.
- R9: Configuration inputs are sampled only when a frame begins. A frame that is running keeps its own slot count, mask, delay, swap, word width and divisor to its end.
- R10: The data, output enable and frame sync change only at the system clock edge where the serial clock falls, and stay stable while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Run enable, sampled at frame boundaries |
| cfg_nch | input | 4 | Slots per frame, 1 to MAX_SLOTS |
| cfg_mask | input | 8 | Per-slot enable, bit p controls slot p |
| cfg_delay | input | 3 | Bit periods from frame sync to the first data bit |
| cfg_swap | input | 1 | Swap the channels within each even/odd slot pair |
| cfg_wlen | input | 6 | Bits per slot, 2 to WORD_W |
| cfg_div | input | 8 | System clocks per serial bit, even, at least 2 |
| in_data | input | 32 | Word for the requested channel |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Word request strobe, one cycle per active slot |
| in_chan | output | 3 | Logical channel being requested |
| sclk_o | output | 1 | Serial bit clock |
| fs_o | output | 1 | Frame sync, one bit period wide |
| sd_o | output | 1 | Serial data, MSB first |
| sd_oe_o | output | 1 | Data output enable, high in active slots |
| underflow_o | output | 1 | Sticky flag for an active slot that found no word |

## Verification
With a zero delay, the bit tick that ends a frame also reloads the configuration, starts the frame sync and fetches the word for slot 0. In the boundary test, the bench changes the slot count, mask, swap and word width halfway through a frame. It then checks three things. First, the remaining bits of that frame still follow the old settings. Second, the next frame sync arrives exactly one old frame length after the previous one. Third, the first bit of the new frame already carries slot 0 under the new mask and swap. In the underflow test, `in_valid` is held low across the same boundary. The bench expects the word fetch and the frame sync to coincide while the slot goes out as zeros with the enable still high.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_SLOT
    } tx_state_e;

endpackage

// File: rtl/tdm_tx_clkgen.sv
module tdm_tx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             sclk
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-2:0] half;

    assign half = div[DIV_W-1:1];
    assign tick = run && (cnt >= div - 1'b1);
    assign sclk = run && (cnt >= {1'b0, half});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: the serial clock is low right after every bit tick
    p_sclk_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !sclk);

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
    parameter int WORD_W = 32,
    parameter int WLEN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    input  logic [WLEN_W-1:0] wlen,
    output logic              msb
);

    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= word << (WLEN_W'(WORD_W) - wlen);
        end else if (shift) begin
            sreg <= sreg << 1;
        end
    end

    assign msb = sreg[WORD_W-1];

    // R3: a load and a shift never land on the same edge
    p_load_shift_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/tdm_tx_port.sv
module tdm_tx_port
    import tdm_tx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_SLOTS = 8,
    parameter int DLY_W     = 3,
    parameter int DIV_W     = 8,
    localparam int SLOT_W   = $clog2(MAX_SLOTS),
    localparam int NCH_W    = $clog2(MAX_SLOTS + 1),
    localparam int WLEN_W   = $clog2(WORD_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [NCH_W-1:0]     cfg_nch,
    input  logic [MAX_SLOTS-1:0] cfg_mask,
    input  logic [DLY_W-1:0]     cfg_delay,
    input  logic                 cfg_swap,
    input  logic [WLEN_W-1:0]    cfg_wlen,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [WORD_W-1:0]    in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic [SLOT_W-1:0]    in_chan,
    output logic                 sclk_o,
    output logic                 fs_o,
    output logic                 sd_o,
    output logic                 sd_oe_o,
    output logic                 underflow_o
);

    tx_state_e state, state_d;

    logic [NCH_W-1:0]     cur_nch;
    logic [MAX_SLOTS-1:0] cur_mask;
    logic [DLY_W-1:0]     cur_delay;
    logic                 cur_swap;
    logic [WLEN_W-1:0]    cur_wlen;
    logic [DIV_W-1:0]     cur_div;

    logic [DLY_W-1:0]     gap_cnt, gap_d;
    logic [SLOT_W-1:0]    slot_pos, pos_d, go_pos, partner;
    logic [WLEN_W-1:0]    bit_idx, bit_d;
    logic                 fs_q, oe_q, unf_q;

    logic                 tick, sclk_raw, run, msb;
    logic [DIV_W-1:0]     div_use;
    logic                 frame_go, slot_go, shift_en, use_new;
    logic                 last_bit, last_slot, go_active;
    logic [NCH_W-1:0]     sel_nch;
    logic [MAX_SLOTS-1:0] sel_mask;
    logic                 sel_swap;
    logic [WLEN_W-1:0]    sel_wlen;
    logic [WORD_W-1:0]    load_word;

    assign run     = cfg_en || (state != ST_IDLE);
    assign div_use = (state == ST_IDLE) ? cfg_div : cur_div;

    tdm_tx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_use),
        .tick  (tick),
        .sclk  (sclk_raw)
    );

    // next-state logic
    always_comb begin
        state_d   = state;
        gap_d     = gap_cnt;
        pos_d     = slot_pos;
        bit_d     = bit_idx;
        frame_go  = 1'b0;
        slot_go   = 1'b0;
        shift_en  = 1'b0;
        go_pos    = '0;
        last_bit  = (bit_idx == cur_wlen - 1'b1);
        last_slot = (NCH_W'(slot_pos) == cur_nch - 1'b1);
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (cfg_en) frame_go = 1'b1;
                end
                ST_GAP: begin
                    if (gap_cnt == cur_delay) begin
                        state_d = ST_SLOT;
                        slot_go = 1'b1;
                    end else begin
                        gap_d = gap_cnt + 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (!last_bit) begin
                        bit_d    = bit_idx + 1'b1;
                        shift_en = 1'b1;
                    end else if (!last_slot) begin
                        slot_go = 1'b1;
                        go_pos  = slot_pos + 1'b1;
                    end else if (cfg_en) begin
                        frame_go = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (frame_go) begin
            if (cfg_delay != '0) begin
                state_d = ST_GAP;
                gap_d   = DLY_W'(1);
            end else begin
                state_d = ST_SLOT;
                slot_go = 1'b1;
            end
        end
        if (slot_go) begin
            pos_d = go_pos;
            bit_d = '0;
        end
    end

    // slot setup uses the incoming configuration when a frame starts
    assign use_new   = frame_go;
    assign sel_nch   = use_new ? cfg_nch  : cur_nch;
    assign sel_mask  = use_new ? cfg_mask : cur_mask;
    assign sel_swap  = use_new ? cfg_swap : cur_swap;
    assign sel_wlen  = use_new ? cfg_wlen : cur_wlen;
    assign go_active = sel_mask[go_pos];
    assign partner   = go_pos ^ SLOT_W'(1);
    assign in_chan   = (sel_swap && (NCH_W'(partner) < sel_nch)) ? partner : go_pos;
    assign in_ready  = slot_go && go_active;
    assign load_word = (in_ready && in_valid) ? in_data : '0;

    tdm_tx_shifter #(.WORD_W(WORD_W), .WLEN_W(WLEN_W)) shifter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (slot_go),
        .shift (shift_en),
        .word  (load_word),
        .wlen  (sel_wlen),
        .msb   (msb)
    );

    // state register and frame configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            gap_cnt   <= '0;
            slot_pos  <= '0;
            bit_idx   <= '0;
            cur_nch   <= NCH_W'(1);
            cur_mask  <= '0;
            cur_delay <= '0;
            cur_swap  <= 1'b0;
            cur_wlen  <= WLEN_W'(2);
            cur_div   <= DIV_W'(2);
        end else begin
            state    <= state_d;
            gap_cnt  <= gap_d;
            slot_pos <= pos_d;
            bit_idx  <= bit_d;
            if (use_new) begin
                cur_nch   <= cfg_nch;
                cur_mask  <= cfg_mask;
                cur_delay <= cfg_delay;
                cur_swap  <= cfg_swap;
                cur_wlen  <= cfg_wlen;
                cur_div   <= cfg_div;
            end
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            oe_q  <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (tick) begin
                fs_q <= frame_go;
                if (slot_go) begin
                    oe_q <= go_active;
                end else if (!shift_en) begin
                    oe_q <= 1'b0;
                end
            end
            if (in_ready && !in_valid) begin
                unf_q <= 1'b1;
            end
        end
    end

    assign sclk_o      = sclk_raw && (state != ST_IDLE);
    assign fs_o        = fs_q;
    assign sd_oe_o     = oe_q;
    assign sd_o        = oe_q && msb;
    assign underflow_o = unf_q;

    // R2: the frame sync is dropped after one bit period
    p_fs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q && tick) |=> !fs_q);

    // R4: the data line is disabled during the delay bits
    p_gap_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !sd_oe_o && !sd_o);

    // R8: the underflow flag never clears by itself
    p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

    // R9: the held configuration moves only when a frame opens
    p_cfg_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_nch != $past(cur_nch)) || (cur_mask != $past(cur_mask))
         || (cur_wlen != $past(cur_wlen))) |-> fs_q);

    // R10: outputs move only on the edge after a bit tick
    p_out_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sd_o) && $stable(fs_o) && $stable(sd_oe_o));

    // R1: nothing toggles while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sclk_o && !sd_oe_o);

endmodule

// File: tb/tdm_tx_port_tb_top.sv
module tdm_tx_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en;
    logic [3:0]  cfg_nch;
    logic [7:0]  cfg_mask;
    logic [2:0]  cfg_delay;
    logic        cfg_swap;
    logic [5:0]  cfg_wlen;
    logic [7:0]  cfg_div;
    logic [31:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_chan;
    logic        sclk_o, fs_o, sd_o, sd_oe_o, underflow_o;

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;
    bit done = 1'b0;

    logic [3:0] p_nch;
    logic [7:0] p_mask;
    logic [2:0] p_delay;
    logic       p_swap;
    logic [5:0] p_wlen;
    logic [7:0] p_div;

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input int ch);
        return 32'hC35A_96E1 ^ (32'(ch) * 32'h2468_ACE3);
    endfunction

    assign in_data = pat(int'(in_chan));

    always @(posedge clk) if (rst_n && in_ready) rdy_cnt <= rdy_cnt + 1;

    tdm_tx_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_nch(cfg_nch),
        .cfg_mask(cfg_mask), .cfg_delay(cfg_delay), .cfg_swap(cfg_swap),
        .cfg_wlen(cfg_wlen), .cfg_div(cfg_div), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
        .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
        .underflow_o(underflow_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int nch, input int mask, input int dly,
                           input int swp, input int wl, input int dv);
        cfg_nch = 4'(nch); cfg_mask = 8'(mask); cfg_delay = 3'(dly);
        cfg_swap = swp[0]; cfg_wlen = 6'(wl); cfg_div = 8'(dv);
    endtask

    task automatic set_pend(input int nch, input int mask, input int dly,
                            input int swp, input int wl, input int dv);
        p_nch = 4'(nch); p_mask = 8'(mask); p_delay = 3'(dly);
        p_swap = swp[0]; p_wlen = 6'(wl); p_div = 8'(dv);
    endtask

    // sample one bit at the serial clock rising edge
    task automatic get_bit(output logic f, output logic s, output logic o);
        do @(negedge clk); while (sclk_o !== 1'b0);
        do @(negedge clk); while (sclk_o !== 1'b1);
        f = fs_o; s = sd_o; o = sd_oe_o;
    endtask

    task automatic check_frame(input int change_at);
        logic f, s, o;
        int n = 0;
        int e_nch, e_dly, e_wl, L, act_slots, r0;
        logic [7:0] e_mask;
        logic e_swap, e_valid;
        do begin get_bit(f, s, o); n++; end while (f !== 1'b1 && n < 600);
        chk("R2", "frame sync found", int'(f), 1);
        r0 = rdy_cnt;
        e_nch = int'(cfg_nch); e_mask = cfg_mask; e_dly = int'(cfg_delay);
        e_swap = cfg_swap; e_wl = int'(cfg_wlen); e_valid = in_valid;
        L = e_dly + e_nch * e_wl;
        act_slots = 0;
        for (int p = 0; p < e_nch; p++) if (e_mask[p]) act_slots++;
        for (int b = 0; b < L; b++) begin
            int pos, bi, ch;
            logic xs, xo;
            string rq;
            if (b > 0) get_bit(f, s, o);
            if (b == change_at) begin
                cfg_nch = p_nch; cfg_mask = p_mask; cfg_delay = p_delay;
                cfg_swap = p_swap; cfg_wlen = p_wlen; cfg_div = p_div;
            end
            if (b < e_dly) begin
                xs = 1'b0; xo = 1'b0; rq = "R4";
            end else begin
                pos = (b - e_dly) / e_wl;
                bi  = (b - e_dly) % e_wl;
                ch  = (e_swap && ((pos ^ 1) < e_nch)) ? (pos ^ 1) : pos;
                xo  = e_mask[pos];
                xs  = (xo && e_valid) ? pat(ch)[e_wl - 1 - bi] : 1'b0;
                rq  = !e_valid ? "R8" : (e_swap ? "R6" : "R3");
            end
            if (change_at >= 0) rq = "R9";
            chk("R2", $sformatf("fs bit %0d", b), int'(f), (b == 0) ? 1 : 0);
            chk((b < e_dly) ? "R4" : "R5", $sformatf("oe bit %0d", b), int'(o), int'(xo));
            chk(rq, $sformatf("sd bit %0d", b), int'(s), int'(xs));
        end
        get_bit(f, s, o);
        chk("R2", "next frame sync after frame length", int'(f), 1);
        if (change_at < 0)
            chk("R7", "word requests per frame", rdy_cnt - r0, act_slots);
    endtask

    task automatic measure_sclk(input int dv);
        logic f, s, o;
        int per = 0, hi = 0, sd_moves = 0;
        logic prev, sd_prev;
        get_bit(f, s, o);
        prev = 1'b1; sd_prev = sd_o;
        forever begin
            @(negedge clk);
            per++;
            if (sclk_o) hi++;
            if (sclk_o && prev && sd_o !== sd_prev) sd_moves++;
            sd_prev = sd_o;
            if (sclk_o && !prev) break;
            prev = sclk_o;
        end
        chk("R1", "sclk period", per, dv);
        chk("R1", "sclk high time", hi, dv / 2);
        chk("R10", "sd change while sclk high", sd_moves, 0);
    endtask

    task automatic t_reset();
        chk("R1", "reset sclk", int'(sclk_o), 0);
        chk("R1", "reset fs", int'(fs_o), 0);
        chk("R5", "reset oe", int'(sd_oe_o), 0);
        chk("R7", "reset ready", int'(in_ready), 0);
        chk("R8", "reset underflow", int'(underflow_o), 0);
        repeat (20) @(negedge clk);
        chk("R1", "disabled sclk", int'(sclk_o), 0);
    endtask

    task automatic t_basic();
        set_cfg(4, 8'h0F, 0, 0, 16, 4);
        cfg_en = 1'b1;
        check_frame(-1);
        measure_sclk(4);
    endtask

    task automatic t_i2s();
        set_cfg(2, 8'h03, 1, 0, 24, 2);
        check_frame(-1);
        check_frame(-1);
        measure_sclk(2);
    endtask

    task automatic t_swap();
        set_cfg(3, 8'h07, 1, 1, 12, 4);
        check_frame(-1);
        check_frame(-1);
    endtask

    task automatic t_sparse();
        set_cfg(8, 8'hA5, 0, 0, 8, 6);
        check_frame(-1);
        check_frame(-1);
        measure_sclk(6);
    endtask

    task automatic t_wide_delay();
        set_cfg(2, 8'h02, 5, 1, 4, 8);
        check_frame(-1);
        check_frame(-1);
    endtask

    task automatic t_boundary();
        set_cfg(4, 8'h0B, 0, 0, 10, 4);
        check_frame(-1);
        set_pend(3, 8'h06, 0, 1, 6, 2);
        check_frame(5);
        check_frame(-1);
        check_frame(-1);
    endtask

    task automatic t_underflow();
        chk("R8", "no underflow yet", int'(underflow_o), 0);
        in_valid = 1'b0;
        check_frame(-1);
        chk("R8", "underflow set", int'(underflow_o), 1);
        in_valid = 1'b1;
        check_frame(-1);
        check_frame(-1);
        chk("R8", "underflow sticky", int'(underflow_o), 1);
    endtask

    task automatic t_disable();
        int hi_seen = 0;
        cfg_en = 1'b0;
        repeat (1200) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sclk_o || fs_o || sd_oe_o) hi_seen++;
        end
        chk("R1", "idle after disable", hi_seen, 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_en = 1'b0; in_valid = 1'b1;
        set_cfg(2, 8'h03, 0, 0, 8, 2);
        set_pend(2, 8'h03, 0, 0, 8, 2);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_i2s();
        t_swap();
        t_sparse();
        t_wide_delay();
        t_boundary();
        t_underflow();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule